// File: doc/BRIEF.md
# Serial Frame CRC-8 Generator and Checker

This block computes the 8-bit checksum that protects a serial command frame. The frame is a command byte followed by one or more data bytes, and the checksum byte follows them on the wire. Message bits enter most significant bit first. A whole byte can be folded in per clock, or a single bit can be folded in per clock when the frame arrives bit-serially. The remainder starts from all ones, the divisor is x^8 + x^4 + x^3 + x^2 + 1, and the emitted checksum is the bitwise complement of the final remainder.

A frame-start pulse rewinds the remainder. A frame-end pulse captures the complemented remainder as the result. In check mode, the result is also compared with a received checksum byte, and a match flag reports the outcome.

Top module: `crc8_frame_gen`

## Requirements
- R1: Each message bit b updates the remainder r as follows: f = r[7] XOR b, then r becomes (r shifted left by one) XOR (f ? 8'h1D : 8'h00).
- R2: After reset, crc_out reads 8'h00 and done and match read 0. A frame_start pulse reloads the remainder with 8'hFF.
- R3: byte_valid folds all eight bits of data_byte in one cycle, bit 7 first. The result equals feeding the same eight bits serially.
- R4: bit_valid folds the single bit data_bit into the remainder in one cycle.
- R5: When byte_valid and bit_valid are high in the same cycle, the byte is used and data_bit has no effect.
- R6: On frame_end, crc_out takes the complement of the remainder one clock later, including any byte or bit presented in the frame_end cycle. done is high for exactly that one cycle.
- R7: Command 8'h01 followed by data 8'h05 produces checksum 8'h9B.
- R8: On frame_end with check_mode high, match becomes 1 one clock later exactly when the computed checksum equals rx_crc. With check_mode low, match becomes 0.
- R9: crc_out and match keep their values until the next frame_end.
- R10: In a cycle with no frame_start, byte_valid or bit_valid, the remainder is unchanged.
- R11: frame_start together with byte_valid or bit_valid folds that input onto the fresh 8'hFF preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| frame_start | input | 1 | Reloads the remainder preset |
| byte_valid | input | 1 | Folds data_byte this cycle |
| data_byte | input | 8 | Message byte, bit 7 sent first |
| bit_valid | input | 1 | Folds data_bit this cycle |
| data_bit | input | 1 | Serial message bit |
| frame_end | input | 1 | Captures the final checksum |
| check_mode | input | 1 | Enables comparison with rx_crc |
| rx_crc | input | 8 | Received checksum byte |
| crc_out | output | 8 | Checksum to append to the frame |
| done | output | 1 | One-cycle pulse when crc_out has been updated |
| match | output | 1 | Received checksum equals the computed one |

## Verification
Every result of this block appears one clock edge after the input that causes it. The remainder follows a data or start input at the next edge, and crc_out, done and match follow frame_end at the next edge. Inputs are driven just after a falling edge. The behavioural model updates on the rising edge from the same inputs, and the outputs are compared with the model on the next falling edge, so each check lands exactly one register stage after its stimulus. Directed checks at those same points compare the known vector, serial-versus-byte equality and priority cases against fixed constants.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  localparam int unsigned CRC_W        = 8;
  localparam int unsigned BYTE_W       = 8;
  localparam logic [CRC_W-1:0] POLY_LO = 8'h1D;
  localparam logic [CRC_W-1:0] PRESET  = 8'hFF;
  localparam logic [CRC_W-1:0] OUT_XOR = 8'hFF;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/crc8_fold.sv
module crc8_fold #(
  parameter int unsigned W     = 8,
  parameter int unsigned STEPS = 8,
  parameter logic [W-1:0] POLY = 8'h1D
) (
  input  logic [W-1:0]     rem_in,
  input  logic [STEPS-1:0] bits_in,
  output logic [W-1:0]     rem_out
);
  logic [W-1:0] stage [0:STEPS];

  assign stage[0] = rem_in;

  // one serial division step per stage, most significant input bit first
  for (genvar i = 0; i < STEPS; i++) begin : g_step
    logic fb;
    assign fb = stage[i][W-1] ^ bits_in[STEPS-1-i];
    assign stage[i+1] = {stage[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign rem_out = stage[STEPS];
endmodule

// File: rtl/crc8_rem_reg.sv
module crc8_rem_reg
  import crc8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic byte_en,
  input  logic bit_en,
  input  crc_t byte_rem,
  input  crc_t bit_rem,
  output crc_t base,
  output crc_t rem_next,
  output crc_t rem_q
);
  logic rem_ce;

  assign base   = start ? PRESET : rem_q;
  assign rem_ce = start | byte_en | bit_en;

  always_comb begin
    rem_next = base;
    if (byte_en)     rem_next = byte_rem;
    else if (bit_en) rem_next = bit_rem;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= PRESET;
    else if (rem_ce) rem_q <= rem_next;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !byte_en && !bit_en) |=> $stable(rem_q)); // R10
  AST_START_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !byte_en && !bit_en) |=> (rem_q == PRESET)); // R2
endmodule

// File: rtl/crc8_result_reg.sv
module crc8_result_reg
  import crc8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fin,
  input  logic chk,
  input  crc_t rx,
  input  crc_t rem_next,
  output crc_t crc_q,
  output logic done_q,
  output logic match_q
);
  crc_t crc_d;
  logic match_d;

  always_comb begin
    crc_d   = rem_next ^ OUT_XOR;
    match_d = chk && (crc_d == rx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q   <= '0;
      match_q <= 1'b0;
    end else if (fin) begin
      crc_q   <= crc_d;
      match_q <= match_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= fin;
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ($stable(crc_q) && $stable(match_q))); // R9
  AST_DONE_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(fin)); // R6
  AST_MATCH_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !chk) |=> !match_q); // R8
endmodule

// File: rtl/crc8_frame_gen.sv
module crc8_frame_gen
  import crc8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             byte_valid,
  input  logic [BYTE_W-1:0] data_byte,
  input  logic             bit_valid,
  input  logic             data_bit,
  input  logic             frame_end,
  input  logic             check_mode,
  input  logic [CRC_W-1:0] rx_crc,
  output logic [CRC_W-1:0] crc_out,
  output logic             done,
  output logic             match
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  crc_t       base, rem_next, rem_q, byte_rem, bit_rem;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  crc8_fold #(.W(CRC_W), .STEPS(BYTE_W), .POLY(POLY_LO)) u_fold_byte (
    .rem_in (base),
    .bits_in(data_byte),
    .rem_out(byte_rem)
  );

  crc8_fold #(.W(CRC_W), .STEPS(1), .POLY(POLY_LO)) u_fold_bit (
    .rem_in (base),
    .bits_in(data_bit),
    .rem_out(bit_rem)
  );

  crc8_rem_reg u_rem (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (frame_start),
    .byte_en (byte_valid),
    .bit_en  (bit_valid),
    .byte_rem(byte_rem),
    .bit_rem (bit_rem),
    .base    (base),
    .rem_next(rem_next),
    .rem_q   (rem_q)
  );

  crc8_result_reg u_res (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fin     (frame_end),
    .chk     (check_mode),
    .rx      (rx_crc),
    .rem_next(rem_next),
    .crc_q   (crc_out),
    .done_q  (done),
    .match_q (match)
  );

  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bit_valid && !byte_valid && !frame_start) |=>
      (rem_q == ({$past(rem_q[CRC_W-2:0]), 1'b0} ^
                 (($past(rem_q[CRC_W-1]) ^ $past(data_bit)) ? POLY_LO : '0)))); // R1
  AST_END_VALUE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_end |=> (crc_out == ~rem_q)); // R6
endmodule

// File: tb/test_crc8_frame_gen.sv
module test_crc8_frame_gen;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 0, byte_valid = 0, bit_valid = 0, data_bit = 0;
  logic       frame_end = 0, check_mode = 0;
  logic [7:0] data_byte = 0, rx_crc = 0;
  logic [7:0] crc_out;
  logic       done, match;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model state
  int  m_rem = 255, m_crc = 0, m_done = 0, m_match = 0, m_rel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc8_frame_gen i_crc8_frame_gen (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
    .data_byte(data_byte), .bit_valid(bit_valid), .data_bit(data_bit),
    .frame_end(frame_end), .check_mode(check_mode), .rx_crc(rx_crc),
    .crc_out(crc_out), .done(done), .match(match)
  );

  function automatic int step(input int r, input int b);
    int f;
    f = ((r >> 7) & 1) ^ b;
    r = (r << 1) & 255;
    if (f != 0) r = r ^ 29;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_rem = 255; m_crc = 0; m_done = 0; m_match = 0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1;
    end else begin
      int r;
      r = frame_start ? 255 : m_rem;
      if (byte_valid) begin
        for (int k = 7; k >= 0; k--) r = step(r, (data_byte >> k) & 1);
      end else if (bit_valid) begin
        r = step(r, data_bit);
      end
      m_rem = r;
      m_done = frame_end;
      if (frame_end) begin
        m_crc   = (~r) & 255;
        m_match = (check_mode && (m_crc == rx_crc)) ? 1 : 0;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model (R6, R8, R9)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R6", "crc_out vs model", crc_out, m_crc);
      check("R6", "done vs model", done, m_done);
      check("R8", "match vs model", match, m_match);
    end
  end

  task automatic cyc(input logic s, input logic bv, input logic [7:0] b,
                     input logic tv, input logic t, input logic e,
                     input logic c, input logic [7:0] rx);
    frame_start = s; byte_valid = bv; data_byte = b; bit_valid = tv;
    data_bit = t; frame_end = e; check_mode = c; rx_crc = rx;
    @(negedge clk);
    frame_start = 0; byte_valid = 0; bit_valid = 0; frame_end = 0;
  endtask

  initial begin
    int c1;
    repeat (3) @(negedge clk);
    check("R2", "reset crc_out", crc_out, 0);
    check("R2", "reset done", done, 0);
    check("R2", "reset match", match, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 known vector, R2 preset
    cyc(1, 0, 8'h00, 0, 0, 0, 0, 8'h00);
    cyc(0, 1, 8'h01, 0, 0, 0, 0, 8'h00);
    cyc(0, 1, 8'h05, 0, 0, 1, 1, 8'h9B);
    check("R7", "vector 01 05", crc_out, 8'h9B);
    check("R8", "match on equal", match, 1);
    check("R6", "done pulse", done, 1);
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 8'h00);
    check("R6", "done one cycle", done, 0);
    check("R9", "crc held", crc_out, 8'h9B);
    check("R9", "match held", match, 1);

    // R11 start with byte, R10 idle gaps
    cyc(1, 1, 8'h01, 0, 0, 0, 0, 8'h00);
    repeat (3) cyc(0, 0, 8'h00, 0, 0, 0, 0, 8'h00);
    cyc(0, 1, 8'h05, 0, 0, 1, 1, 8'h00);
    check("R11", "start+byte vector", crc_out, 8'h9B);
    check("R8", "mismatch clears", match, 0);

    // R3 / R4 serial feed equals byte feed
    cyc(1, 0, 8'h00, 0, 0, 0, 0, 8'h00);
    for (int k = 7; k >= 0; k--) cyc(0, 0, 8'h00, 1, (8'h01 >> k) & 1, 0, 0, 8'h00);
    for (int k = 7; k >= 0; k--) cyc(0, 0, 8'h00, 1, (8'h05 >> k) & 1, k == 0, 1, 8'h9B);
    check("R3", "serial equals byte", crc_out, 8'h9B);
    check("R4", "serial match", match, 1);

    // R5 byte wins over bit; R10 check via result
    cyc(1, 0, 8'h00, 0, 0, 0, 0, 8'h00);
    cyc(0, 1, 8'h01, 1, 1, 0, 0, 8'h00);
    cyc(0, 1, 8'h05, 1, 1, 1, 0, 8'h9B);
    check("R5", "bit ignored", crc_out, 8'h9B);
    check("R8", "check_mode low", match, 0);

    // R1 single bit from preset: 1 then ff -> shift, fb=0 -> fe; crc=01
    cyc(1, 0, 8'h00, 1, 1, 1, 1, 8'h01);
    check("R1", "one bit step", crc_out, 8'h01);
    // fb=1: bit 0 on ff -> fe^1d=e3; crc=1c
    cyc(1, 0, 8'h00, 1, 0, 1, 0, 8'h00);
    check("R1", "feedback step", crc_out, 8'h1C);

    // further patterns against the model
    cyc(1, 1, 8'hA5, 0, 0, 0, 0, 8'h00);
    cyc(0, 1, 8'h3C, 0, 0, 0, 0, 8'h00);
    cyc(0, 1, 8'hFF, 0, 0, 1, 1, 8'h00);
    c1 = m_crc;
    check("R6", "multi-byte model", crc_out, c1);
    cyc(0, 0, 8'h00, 0, 0, 1, 1, c1[7:0]);
    check("R9", "re-end without data", crc_out, c1);
    check("R8", "match second end", match, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule